// File: doc/BRIEF.md
# Tick-Driven Watchdog with Interrupt Combiner

This block is a watchdog timer that counts down on a slow periodic tick, nominally 32 Hz, so one unit of timeout is 31.25 ms. Software programs a 6-bit timeout through a small register interface. It then has to restart the countdown before the count runs out. If the count runs out, a watchdog flag is raised. Two further event sources, an alarm and a power-fail indication, raise flags of their own. Each of the three flags has an enable bit, and the enabled flags are merged onto one shared interrupt pin.

The timeout field is guarded by a lock bit. A write can change the timeout only if the lock bit stored by an earlier write is 0. Every write stores a new lock bit. Reading the flag register returns the flags and clears them. The interrupt pin can be active high or active low. It has two modes. In level mode it stays asserted while any enabled flag is set. In pulse mode it asserts for a fixed number of system clocks when an enabled event occurs.

Top module: `rtc_wdog_irq`

## Requirements
- R1: After reset, the timeout is 0, the lock bit is 0, all flags are 0, all enables are 0, the polarity bit selects active low, and the pin reads 1 (inactive). Register reads at addresses 0, 1 and 2 all return 0x00.
- R2: Address 0 is the watchdog register, with the timeout in bits [5:0], restart in bit 6 and lock in bit 7. A write there while the stored lock bit is 0 sets the timeout to bits [5:0], and reads of address 0 return it. Every write to address 0 stores bit 7 as the new lock bit.
- R3: While the stored lock bit is 1, a write to address 0 leaves the timeout unchanged but still updates the lock bit. After a write with bit 7 at 0, the next write can change the timeout again.
- R4: Bit 6 of address 0 always reads as 0. Writing 1 to it reloads the countdown from the timeout. A write that is accepted into the timeout field also reloads the countdown, using the new value.
- R5: While the timeout is nonzero, each tick lowers the countdown by one. The watchdog flag (flag register bit 0) is set by the N-th tick after a reload with value N. A restart issued before that tick postpones the flag by a full N ticks.
- R6: A timeout of 0 disables the watchdog: no number of ticks sets the watchdog flag.
- R7: A read of address 2 returns the watchdog flag in bit 0, the alarm flag in bit 1 and the power-fail flag in bit 2, and clears them. If a flag-setting event arrives in the same cycle as the read, that flag stays set.
- R8: Address 1 is interrupt control: bit 7 enables the watchdog flag, bit 6 the alarm flag and bit 5 the power-fail flag. In level mode (bit 0 = 0), the pin is active while any enabled flag is set. A set flag whose enable is 0 does not drive the pin.
- R9: Bit 1 of address 1 selects the polarity: 1 makes the pin active high, 0 makes it active low.
- R10: In pulse mode (bit 0 of address 1 = 1), an enabled flag-setting event makes the pin active for exactly PULSE_CLKS clocks. After that the pin is inactive, even if the flag is still set.
- R11: A one-cycle pulse on the alarm or power-fail input sets its flag whether or not the flag is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock pulse per timeout unit (32 Hz) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 2 clears the flags |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, valid in the same cycle |
| alarm_evt | input | 1 | Alarm event pulse |
| pwrfail_evt | input | 1 | Power-fail event pulse |
| irq_pin | output | 1 | Shared interrupt pin |

## Verification
The bound checker watches, on every cycle, the properties that relate one cycle to the next. It checks that a locked write leaves the timeout alone and that the restart bit never reads back as 1. It checks that the watchdog flag can only rise after a nonzero timeout. It checks that each event input sets its flag, and that a flag read without a simultaneous event clears the flag. The countdown length, the effect of a restart on the expiry tick, and the level versus pulse behaviour of the pin under both polarities depend on sequences of many ticks and register accesses. Only the bench's directed scenarios can show those.

// File: rtl/rwd_pkg.sv
// Package: shared register addresses and bit positions of the tick watchdog.
// Assumes an 8-bit register interface with a 2-bit address.
package rwd_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int TMO_W   = 6;
    localparam int NSRC    = 3;

    localparam logic [ADDR_W-1:0] A_WDOG  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS = 2'd2;

    // watchdog register bits
    localparam int B_RESTART = 6;
    localparam int B_LOCK    = 7;

    // control register bits
    localparam int B_PULSE = 0;
    localparam int B_POL   = 1;
    localparam int B_PFEN  = 5;
    localparam int B_ALEN  = 6;
    localparam int B_WDEN  = 7;

    // flag indices
    localparam int F_WD = 0;
    localparam int F_AL = 1;
    localparam int F_PF = 2;
endpackage

// File: rtl/rwd_counter.sv
// Module: countdown of the watchdog, one step per tick.
// Assumes tick is a single-clock pulse. A reload wins over a tick in the same cycle.
// expire pulses for one clock on the tick that takes the count from 1 to 0.
module rwd_counter #(
    parameter int TMO_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [TMO_W-1:0] load_val,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_q;

    // expiry when a tick meets a count of one and no reload is pending
    assign expire = tick && !reload && (cnt_q == TMO_W'(1));

    // count register: reload, else step down on tick while nonzero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - TMO_W'(1);
        end
    end
endmodule

// File: rtl/rwd_irq_out.sv
// Module: merges flags into one interrupt pin, with level or pulse mode.
// Assumes set_evt marks the cycle a flag is set. A new enabled event in pulse mode restarts the pulse.
module rwd_irq_out #(
    parameter int NSRC       = 3,
    parameter int PULSE_CLKS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] set_evt,
    input  logic [NSRC-1:0] en,
    input  logic            active_high,
    input  logic            pulse_mode,
    output logic            pin
);
    localparam int PW = $clog2(PULSE_CLKS + 1);

    logic [PW-1:0] pcnt_q;
    logic          level_act;
    logic          trig;
    logic          act;

    // enabled-source summaries
    assign level_act = |(flags & en);
    assign trig      = |(set_evt & en);

    // pulse length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (trig && pulse_mode) begin
            pcnt_q <= PW'(PULSE_CLKS);
        end else if (pcnt_q != '0) begin
            pcnt_q <= pcnt_q - PW'(1);
        end
    end

    // mode and polarity selection for the pin
    always_comb begin
        act = pulse_mode ? (pcnt_q != '0) : level_act;
        pin = active_high ? act : !act;
    end
endmodule

// File: rtl/rtc_wdog_irq.sv
// Module: top of the tick watchdog. Holds the three registers and ties the
// countdown and pin logic together.
// Assumes reads and writes do not occur in the same cycle.
module rtc_wdog_irq #(
    parameter int PULSE_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       alarm_evt,
    input  logic       pwrfail_evt,
    output logic       irq_pin
);
    import rwd_pkg::*;

    logic [TMO_W-1:0] timeout_q;
    logic             lock_q;
    logic             wd_en_q, al_en_q, pf_en_q, pol_q, pulse_q;
    logic [NSRC-1:0]  flags_q;

    logic             wd_wr, ctl_wr, flg_rd, tmo_acc, reload, expire;
    logic [TMO_W-1:0] load_val;
    logic [NSRC-1:0]  set_evt;

    // decode of the register strobes
    assign wd_wr    = reg_wr && reg_addr == A_WDOG;
    assign ctl_wr   = reg_wr && reg_addr == A_CTRL;
    assign flg_rd   = reg_rd && reg_addr == A_FLAGS;
    assign tmo_acc  = wd_wr && !lock_q;
    assign reload   = tmo_acc || (wd_wr && reg_wdata[B_RESTART]);
    assign load_val = tmo_acc ? reg_wdata[TMO_W-1:0] : timeout_q;

    // watchdog register: timeout guarded by the stored lock bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= '0;
            lock_q    <= 1'b0;
        end else if (wd_wr) begin
            lock_q <= reg_wdata[B_LOCK];
            if (!lock_q) timeout_q <= reg_wdata[TMO_W-1:0];
        end
    end

    // interrupt control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {wd_en_q, al_en_q, pf_en_q, pol_q, pulse_q} <= '0;
        end else if (ctl_wr) begin
            wd_en_q <= reg_wdata[B_WDEN];
            al_en_q <= reg_wdata[B_ALEN];
            pf_en_q <= reg_wdata[B_PFEN];
            pol_q   <= reg_wdata[B_POL];
            pulse_q <= reg_wdata[B_PULSE];
        end
    end

    rwd_counter #(.TMO_W(TMO_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .reload   (reload),
        .load_val (load_val),
        .expire   (expire)
    );

    // event vector in flag order
    always_comb begin
        set_evt       = '0;
        set_evt[F_WD] = expire;
        set_evt[F_AL] = alarm_evt;
        set_evt[F_PF] = pwrfail_evt;
    end

    // flag register: a read clears, a new event in the same cycle is kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flg_rd ? '0 : flags_q) | set_evt;
        end
    end

    rwd_irq_out #(.NSRC(NSRC), .PULSE_CLKS(PULSE_CLKS)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flags       (flags_q),
        .set_evt     (set_evt),
        .en          ({pf_en_q, al_en_q, wd_en_q}),
        .active_high (pol_q),
        .pulse_mode  (pulse_q),
        .pin         (irq_pin)
    );

    // read data multiplexer
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_WDOG: begin
                reg_rdata[TMO_W-1:0] = timeout_q;
                reg_rdata[B_LOCK]    = lock_q;
            end
            A_CTRL: begin
                reg_rdata[B_WDEN]  = wd_en_q;
                reg_rdata[B_ALEN]  = al_en_q;
                reg_rdata[B_PFEN]  = pf_en_q;
                reg_rdata[B_POL]   = pol_q;
                reg_rdata[B_PULSE] = pulse_q;
            end
            A_FLAGS: reg_rdata[NSRC-1:0] = flags_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_wdog_irq_chk.sv
// Module: property checker for rtc_wdog_irq. It is bound into every instance of the top module.
module rtc_wdog_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       alarm_evt,
    input logic       pwrfail_evt,
    input logic [5:0] timeout_q,
    input logic       lock_q,
    input logic [2:0] flags_q
);
    // R3: a write while locked leaves the timeout untouched
    assert_locked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && lock_q) |=> $stable(timeout_q));

    // R4: the restart bit never reads as 1
    assert_restart_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> !reg_rdata[6]);

    // R6: the watchdog flag only rises after a nonzero timeout
    assert_zero_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[0]) |-> $past(timeout_q) != 6'd0);

    // R11: each event input sets its flag
    assert_alarm_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> flags_q[1]);
    assert_pwrfail_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pwrfail_evt |=> flags_q[2]);

    // R7: a read with no coinciding event clears the event flags
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2 && !alarm_evt && !pwrfail_evt) |=> (flags_q[2:1] == 2'b00));
endmodule

bind rtc_wdog_irq rtc_wdog_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .alarm_evt   (alarm_evt),
    .pwrfail_evt (pwrfail_evt),
    .timeout_q   (timeout_q),
    .lock_q      (lock_q),
    .flags_q     (flags_q)
);

// File: tb/rtc_wdog_irq_test.sv
// Bench: directed scenarios for rtc_wdog_irq. Each task checks its own results.
module rtc_wdog_irq_test;
    localparam int PULSE_CLKS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       alarm = 1'b0;
    logic       pf = 1'b0;
    logic       pin;

    int total = 0;
    int failed = 0;

    always #2.5 clk = ~clk;

    rtc_wdog_irq #(.PULSE_CLKS(PULSE_CLKS)) uut (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .reg_wr (wr), .reg_rd (rd), .reg_addr (addr),
        .reg_wdata (wdata), .reg_rdata (rdata),
        .alarm_evt (alarm), .pwrfail_evt (pf), .irq_pin (pin)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_event(input logic a, input logic p);
        @(negedge clk); alarm = a; pf = p;
        @(negedge clk); alarm = 1'b0; pf = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 pin idle", int'(pin), 1);
        do_read(2'd0, d); check("R1 wdog reg", int'(d), 0);
        do_read(2'd1, d); check("R1 ctrl reg", int'(d), 0);
        do_read(2'd2, d); check("R1 flags reg", int'(d), 0);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        do_write(2'd0, 8'h85);
        do_read(2'd0, d); check("R2 timeout and lock stored", int'(d), 'h85);
        do_write(2'd0, 8'h92);
        do_read(2'd0, d); check("R3 locked write ignored", int'(d), 'h85);
        do_write(2'd0, 8'h00);
        do_read(2'd0, d); check("R3 unlock keeps timeout", int'(d), 'h05);
        do_write(2'd0, 8'h12);
        do_read(2'd0, d); check("R3 timeout writable again", int'(d), 'h12);
    endtask

    task automatic t_expiry();
        logic [7:0] d;
        do_write(2'd1, 8'h00);
        do_write(2'd0, 8'h85);
        do_read(2'd2, d);
        do_ticks(4);
        do_read(2'd2, d); check("R5 no flag before N ticks", int'(d), 0);
        do_ticks(1);
        do_read(2'd2, d); check("R5 flag on N-th tick", int'(d), 1);
        do_read(2'd2, d); check("R7 flag cleared by read", int'(d), 0);
        do_write(2'd0, 8'hC0);
        do_read(2'd0, d); check("R4 restart reads zero, timeout kept", int'(d), 'h85);
        do_ticks(3);
        do_write(2'd0, 8'hC0);
        do_ticks(4);
        do_read(2'd2, d); check("R4 restart postpones expiry", int'(d), 0);
        do_ticks(1);
        do_read(2'd2, d); check("R4 expiry N ticks after restart", int'(d), 1);
    endtask

    task automatic t_zero();
        logic [7:0] d;
        do_write(2'd0, 8'h00);
        do_write(2'd0, 8'h00);
        do_ticks(70);
        do_read(2'd2, d); check("R6 zero timeout never expires", int'(d), 0);
    endtask

    task automatic t_level();
        logic [7:0] d;
        do_write(2'd1, 8'h40);
        check("R9 active low idle", int'(pin), 1);
        do_event(1'b1, 1'b0);
        check("R8 alarm drives pin low", int'(pin), 0);
        do_event(1'b0, 1'b1);
        do_read(2'd2, d); check("R7 alarm and pwrfail bits", int'(d), 'h06);
        check("R8 pin released after read", int'(pin), 1);
        do_event(1'b0, 1'b1);
        check("R8 disabled flag leaves pin", int'(pin), 1);
        do_write(2'd1, 8'h22);
        check("R9 active high asserted", int'(pin), 1);
        do_read(2'd2, d); check("R11 disabled pwrfail still flagged", int'(d), 'h04);
        check("R9 active high released", int'(pin), 0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        @(negedge clk); addr = 2'd2; rd = 1'b1; alarm = 1'b1; #1 d = rdata;
        check("R7 read before set sees zero", int'(d), 0);
        @(negedge clk); rd = 1'b0; alarm = 1'b0;
        do_read(2'd2, d); check("R7 set wins over clear", int'(d), 'h02);
    endtask

    task automatic t_pulse();
        logic [7:0] d;
        do_write(2'd1, 8'h83);
        do_write(2'd0, 8'h02);
        do_ticks(1);
        check("R10 pin idle before expiry", int'(pin), 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        for (int i = 0; i < PULSE_CLKS; i++) begin
            check($sformatf("R10 pulse active clk %0d", i), int'(pin), 1);
            @(negedge clk);
        end
        check("R10 pulse ends", int'(pin), 0);
        do_read(2'd2, d); check("R10 flag still set after pulse", int'(d), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_expiry();
        t_zero();
        t_level();
        t_same_cycle();
        t_pulse();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        failed++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule